// File: doc/BRIEF.md
# Signed Add/Subtract Seven-Segment Formatter

This combinational block takes two small two's-complement operands and an operation select. It adds or subtracts them and produces the segment patterns for four seven-segment digits: operand A, operand B, a sign digit and a result digit. Every value is shown in sign-magnitude form. A negative operand shows its magnitude and lights its own decimal point. A negative result shows its magnitude on the result digit and a minus bar on the sign digit.

If the signed result does not fit the operand width, the wrapped value is not shown. The sign and result digits instead spell out an error mark. Subtraction reuses the adder: B is inverted and the carry-in is set to one. The two conversions, two's complement to sign-magnitude and back, are package functions that other blocks can reuse.

The block has no clock, no reset and no state. It sits between the operand inputs (switches and a push button on a board) and a digit driver that scans or latches the segment lines.

Top module: `sfm_signed_display`

## Requirements
- R1: With `op_sub` = 0 and no overflow, the result digit shows the magnitude of A+B, where A and B are 4-bit two's-complement values.
- R2: With `op_sub` = 1 and no overflow, the result digit shows the magnitude of A−B. The difference is formed by adding the bitwise inverse of B with a carry-in of 1.
- R3: Overflow occurs when the adder inputs share a sign and the sum's sign differs from it, that is, when the true result lies outside −8..7. On overflow, `seg_sign` = 7'h06 ('E') and `seg_res` = 7'h2F ('r'). For example, 4+5 overflows.
- R4: When the result is negative and there is no overflow, `seg_sign` = 7'h3F (only segment g lit).
- R5: When the result is zero or positive and there is no overflow, `seg_sign` = 7'h7F (blank).
- R6: When an operand is negative (bit 3 set), its decimal point output is 0 (lit) and its digit shows the magnitude. −8 shows 8.
- R7: When an operand is zero or positive, its decimal point output is 1 (dark) and its digit shows the value unchanged.
- R8: Segment buses are active-low and ordered {g,f,e,d,c,b,a} in bits 6..0. Digits 0–9 and A–F use the usual hex shapes, so that 0 = 7'h40, 1 = 7'h79 and 8 = 7'h00.
- R9: The sign and result decimal point outputs are always 1 (dark).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | Operand A, two's complement |
| b_in | input | 4 | Operand B, two's complement |
| op_sub | input | 1 | 0 selects A+B, 1 selects A−B |
| seg_a | output | 7 | Operand A digit, active-low {g..a} |
| dp_a_n | output | 1 | Operand A decimal point, active-low, lit when A is negative |
| seg_b | output | 7 | Operand B digit, active-low {g..a} |
| dp_b_n | output | 1 | Operand B decimal point, active-low, lit when B is negative |
| seg_sign | output | 7 | Sign digit: blank, minus or 'E' |
| dp_sign_n | output | 1 | Sign digit decimal point, held dark |
| seg_res | output | 7 | Result digit: magnitude or 'r' |
| dp_res_n | output | 1 | Result digit decimal point, held dark |

## Verification
The bench builds the block with its default operand width of 4 bits. At that width the whole input space is only 512 combinations, so every pairing of A, B and operation is driven against an integer reference model. This covers the −8 magnitude case, every overflow boundary (7+1, −8−1, −8+−1, 4+5) and every transition between a blank and a minus sign digit. Zero results, including −8−(−8), confirm that a zero difference leaves the sign digit blank.

// File: rtl/sgn_fmt_pkg.sv
`timescale 1ns/1ps
package sgn_fmt_pkg;

    // Operand width shared by the formatter and its sub-blocks.
    localparam int OPW   = 4;
    localparam int SEG_W = 7;
    localparam int HEX_W = 4;

    typedef logic [OPW-1:0]   word_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [HEX_W-1:0] hex_t;

    typedef struct packed {
        logic  neg;
        word_t mag;
    } sm_t;

    // Active-low glyphs, bit order {g,f,e,d,c,b,a}.
    localparam seg_t GLYPH_BLANK = 7'h7F;
    localparam seg_t GLYPH_MINUS = 7'h3F;
    localparam seg_t GLYPH_E     = 7'h06;
    localparam seg_t GLYPH_R     = 7'h2F;

    // Two's complement to sign-magnitude. The magnitude is unsigned and
    // OPW bits wide, so the most negative value maps to 2**(OPW-1).
    function automatic sm_t twos_to_sm(input word_t x);
        sm_t r;
        r.neg = x[OPW-1];
        r.mag = x[OPW-1] ? word_t'(~x + word_t'(1)) : x;
        return r;
    endfunction

    // Sign-magnitude back to two's complement.
    function automatic word_t sm_to_twos(input sm_t s);
        return s.neg ? word_t'(~s.mag + word_t'(1)) : s.mag;
    endfunction

endpackage

// File: rtl/sfm_ripple_addsub.sv
`timescale 1ns/1ps
module sfm_ripple_addsub
    import sgn_fmt_pkg::*;
#(
    parameter int W = OPW
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] y_eff;
    logic [W:0]   carry;

    assign y_eff    = sub ? ~y : y;
    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = x[i] ^ y_eff[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y_eff[i]) | (carry[i] & (x[i] ^ y_eff[i]));
    end

    // Same-signed inputs giving a sum of the other sign.
    assign ovf = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);

    always_comb begin
        if (!$isunknown({x, y, sub})) begin
            AST_ADDSUB_WRAP: assert (sum == (sub ? W'(x - y) : W'(x + y))) // R2
                else $error("adder result mismatch");
            AST_OVF_RANGE: assert (ovf == ((sub ? ($signed({x[W-1], x}) - $signed({y[W-1], y}))
                                                : ($signed({x[W-1], x}) + $signed({y[W-1], y})))
                                           != $signed({sum[W-1], sum}))) // R3
                else $error("overflow flag mismatch");
        end
    end
endmodule

// File: rtl/sfm_hex_seg.sv
`timescale 1ns/1ps
module sfm_hex_seg
    import sgn_fmt_pkg::*;
(
    input  hex_t nib,
    output seg_t seg
);
    always_comb begin
        unique case (nib)
            4'h0: seg = 7'h40;
            4'h1: seg = 7'h79;
            4'h2: seg = 7'h24;
            4'h3: seg = 7'h30;
            4'h4: seg = 7'h19;
            4'h5: seg = 7'h12;
            4'h6: seg = 7'h02;
            4'h7: seg = 7'h78;
            4'h8: seg = 7'h00;
            4'h9: seg = 7'h10;
            4'hA: seg = 7'h08;
            4'hB: seg = 7'h03;
            4'hC: seg = 7'h46;
            4'hD: seg = 7'h21;
            4'hE: seg = 7'h06;
            default: seg = 7'h0E;
        endcase
    end
endmodule

// File: rtl/sfm_operand_view.sv
`timescale 1ns/1ps
module sfm_operand_view
    import sgn_fmt_pkg::*;
(
    input  word_t val,
    output seg_t  seg,
    output logic  dp_n
);
    sm_t sm;
    assign sm   = twos_to_sm(val);
    assign dp_n = ~sm.neg;

    sfm_hex_seg u_enc (.nib(hex_t'(sm.mag)), .seg(seg));

    always_comb begin
        if (!$isunknown(val)) begin
            AST_SM_ROUNDTRIP: assert (sm_to_twos(sm) == val) // R6
                else $error("sign-magnitude round trip failed");
            AST_POS_MAG_SAME: assert (val[OPW-1] || (sm.mag == val)) // R7
                else $error("positive operand magnitude altered");
        end
    end
endmodule

// File: rtl/sfm_result_view.sv
`timescale 1ns/1ps
module sfm_result_view
    import sgn_fmt_pkg::*;
(
    input  word_t sum,
    input  logic  ovf,
    output seg_t  seg_sign,
    output seg_t  seg_res
);
    sm_t  sm;
    seg_t mag_seg;

    assign sm = twos_to_sm(sum);

    sfm_hex_seg u_enc (.nib(hex_t'(sm.mag)), .seg(mag_seg));

    always_comb begin
        if (ovf) begin
            seg_sign = GLYPH_E;
            seg_res  = GLYPH_R;
        end else begin
            seg_sign = sm.neg ? GLYPH_MINUS : GLYPH_BLANK;
            seg_res  = mag_seg;
        end
    end

    always_comb begin
        if (!$isunknown({sum, ovf})) begin
            AST_OVF_ERROR: assert (!ovf || (seg_sign == GLYPH_E && seg_res == GLYPH_R)) // R3
                else $error("overflow not flagged on display");
            AST_NEG_MINUS: assert (ovf || !sum[OPW-1] || seg_sign == GLYPH_MINUS) // R4
                else $error("negative result without minus");
            AST_POS_BLANK: assert (ovf || sum[OPW-1] || seg_sign == GLYPH_BLANK) // R5
                else $error("non-negative result with sign lit");
        end
    end
endmodule

// File: rtl/sfm_signed_display.sv
`timescale 1ns/1ps
module sfm_signed_display
    import sgn_fmt_pkg::*;
(
    input  logic [3:0] a_in,
    input  logic [3:0] b_in,
    input  logic       op_sub,
    output logic [6:0] seg_a,
    output logic       dp_a_n,
    output logic [6:0] seg_b,
    output logic       dp_b_n,
    output logic [6:0] seg_sign,
    output logic       dp_sign_n,
    output logic [6:0] seg_res,
    output logic       dp_res_n
);
    word_t sum;
    logic  ovf;

    sfm_operand_view u_view_a (.val(a_in), .seg(seg_a), .dp_n(dp_a_n));
    sfm_operand_view u_view_b (.val(b_in), .seg(seg_b), .dp_n(dp_b_n));

    sfm_ripple_addsub #(.W(OPW)) u_core (
        .x(a_in), .y(b_in), .sub(op_sub), .sum(sum), .ovf(ovf)
    );

    sfm_result_view u_view_r (
        .sum(sum), .ovf(ovf), .seg_sign(seg_sign), .seg_res(seg_res)
    );

    assign dp_sign_n = 1'b1;
    assign dp_res_n  = 1'b1;

    always_comb begin
        if (!$isunknown({a_in, b_in})) begin
            AST_DP_TRACKS_SIGN: assert ((dp_a_n != a_in[3]) && (dp_b_n != b_in[3])) // R6
                else $error("operand decimal point wrong");
            AST_DP_IDLE: assert (dp_sign_n && dp_res_n) // R9
                else $error("sign/result dp lit");
        end
    end
endmodule

// File: tb/tb_sfm_signed_display.sv
`timescale 1ns/1ps
module tb_sfm_signed_display;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [3:0] a_in, b_in;
    logic       op_sub;
    logic [6:0] seg_a, seg_b, seg_sign, seg_res;
    logic       dp_a_n, dp_b_n, dp_sign_n, dp_res_n;

    sfm_signed_display dut (
        .a_in(a_in), .b_in(b_in), .op_sub(op_sub),
        .seg_a(seg_a), .dp_a_n(dp_a_n), .seg_b(seg_b), .dp_b_n(dp_b_n),
        .seg_sign(seg_sign), .dp_sign_n(dp_sign_n),
        .seg_res(seg_res), .dp_res_n(dp_res_n)
    );

    typedef struct {
        int         a, b, sub;
        logic [6:0] e_seg_a, e_seg_b, e_sign, e_res;
        logic       e_dpa, e_dpb;
        bit         ovf, neg;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected glyphs from R8.
    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
            4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
            8: return 7'h00;  9: return 7'h10;  10: return 7'h08; 11: return 7'h03;
            12: return 7'h46; 13: return 7'h21; 14: return 7'h06; default: return 7'h0E;
        endcase
    endfunction

    function automatic int sval(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    function automatic int absi(input int v);
        return v < 0 ? -v : v;
    endfunction

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp,
                       input item_t it);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s a=%0d b=%0d sub=%0d actual=%h expected=%h",
                     tag, it.a, it.b, it.sub, act, exp);
        end
    endtask

    // Driver: applies one stimulus and pushes the expected item.
    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic s);
        item_t it;
        int r;
        @(posedge clk);
        #1;
        a_in = a; b_in = b; op_sub = s;
        it.a = sval(a); it.b = sval(b); it.sub = int'(s);
        r = s ? it.a - it.b : it.a + it.b;
        it.ovf = (r > 7) || (r < -8);
        it.neg = r < 0;
        it.e_seg_a = glyph(absi(it.a));
        it.e_seg_b = glyph(absi(it.b));
        it.e_dpa = (it.a >= 0);
        it.e_dpb = (it.b >= 0);
        if (it.ovf) begin
            it.e_sign = 7'h06; it.e_res = 7'h2F;
        end else begin
            it.e_sign = it.neg ? 7'h3F : 7'h7F;
            it.e_res  = glyph(absi(r));
        end
        q.push_back(it);
    endtask

    // Monitor: pops and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.a < 0 ? "R6 seg_a" : "R7 seg_a", seg_a, it.e_seg_a, it);
                chk(it.b < 0 ? "R6 seg_b" : "R7 seg_b", seg_b, it.e_seg_b, it);
                chk(it.a < 0 ? "R6 dp_a" : "R7 dp_a", {6'd0, dp_a_n}, {6'd0, it.e_dpa}, it);
                chk(it.b < 0 ? "R6 dp_b" : "R7 dp_b", {6'd0, dp_b_n}, {6'd0, it.e_dpb}, it);
                if (it.ovf) begin
                    chk("R3 sign", seg_sign, it.e_sign, it);
                    chk("R3 res", seg_res, it.e_res, it);
                end else begin
                    chk(it.neg ? "R4 sign" : "R5 sign", seg_sign, it.e_sign, it);
                    chk(it.sub != 0 ? "R2 res" : "R1 res", seg_res, it.e_res, it);
                end
                chk("R9 dp_sign", {6'd0, dp_sign_n}, 7'd1, it);
                chk("R9 dp_res", {6'd0, dp_res_n}, 7'd1, it);
            end
        end
    end

    // Watchdog.
    initial begin
        #900us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        a_in = 4'd0; b_in = 4'd0; op_sub = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // Idle state: zeros everywhere, R8 glyph for 0 on all digits.
        @(negedge clk);
        begin
            item_t z;
            z.a = 0; z.b = 0; z.sub = 0;
            chk("R8 idle seg_a", seg_a, 7'h40, z);
            chk("R8 idle seg_res", seg_res, 7'h40, z);
            chk("R5 idle sign", seg_sign, 7'h7F, z);
        end
        // Named corners: 4+5 overflow (R3), -8 shown as 8 (R6), 7+1, -8-1.
        drive(4'd4, 4'd5, 1'b0);
        drive(4'h8, 4'd0, 1'b0);
        drive(4'd7, 4'd1, 1'b0);
        drive(4'h8, 4'd1, 1'b1);
        drive(4'h8, 4'h8, 1'b1);
        // Exhaustive sweep (R1, R2, R4, R5, R8).
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    drive(4'(a), 4'(b), 1'(s));
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule